// File: doc/BRIEF.md
# Power-up reset sequencing controller

This block produces the chip-wide reset. It decides when that reset is released after power arrives, after the supply sags, or when the main oscillator restarts on leaving sleep. Two timed stages sit in series. The first is a supply settling delay, counted in ticks of a slow internal RC clock. The second is an oscillator settling count, taken in ticks of the main oscillator. It runs only for crystal or resonator modes, and only after power-on or a wake from sleep.

A brown-out path watches a supply-low comparator flag. It ignores dips shorter than a programmable number of RC ticks. A longer dip puts the chip back into reset, and reset stays asserted until the flag clears. The supply settling delay then runs again, and any new sag while that delay is counting sends the sequence straight back to brown-out hold.

The block runs on one sampling clock. The two slow time bases arrive as single-cycle tick enables, produced outside from the RC oscillator and the main oscillator. The asynchronous supply-low and wake inputs each pass through a two-flop synchronizer before use. Two sticky flags record whether the most recent reset came from power-on or from brown-out.

Top module: `pwr_rst_seq`

## Requirements
- R1: While rst_ni is low, chip_rst_o is 1, por_flag_o is 1 and bor_flag_o is 0.
- R2: A one-cycle por_i pulse holds chip_rst_o high for exactly 1 + PWRT_TICKS + OST_CYCLES sampling cycles, when the delay is enabled, the mode needs the oscillator count, and both tick inputs are high every cycle.
- R3: With pwrt_en_i = 0, the supply settling delay is skipped and contributes no cycles.
- R4: osc_mode_i encodes 0 = low-power crystal, 1 = standard crystal, 2 = high-speed crystal, 3 = external/RC clock. The oscillator count of OST_CYCLES runs for codes 0 to 2 and is skipped for code 3.
- R5: The settling delay advances only on rc_tick_i. The oscillator count advances only on osc_tick_i. Without its own tick, each stage holds reset indefinitely.
- R6: The synchronized supply-low flag trips a brown-out only after BOR_TICKS consecutive rc_tick_i ticks while it is high. Shorter dips leave chip_rst_o and bor_flag_o untouched. BOR_TICKS must be at least 2.
- R7: With bor_en_i = 0, supply_low_i has no effect.
- R8: After a brown-out trip, reset is held while the synchronized flag stays high. Once it clears, only the settling delay runs before release, and no oscillator count runs in any mode.
- R9: With bor_en_i = 1, a supply-low reading during the settling delay returns the sequence at once to brown-out hold, without filtering, and the delay restarts from zero.
- R10: A rising edge of the synchronized wake_i while out of reset starts the oscillator count, with chip_rst_o high, for codes 0 to 2. It has no effect for code 3, and it leaves both flags unchanged.
- R11: Power-on sets por_flag_o and clears bor_flag_o. A brown-out trip sets bor_flag_o and clears por_flag_o. A flag_clr_i pulse clears both. A set in the same cycle wins over a clear.
- R12: por_i overrides every other input and forces the power-on hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | sampling clock |
| rst_ni | input | 1 | asynchronous active-low reset of the controller's own flops |
| por_i | input | 1 | power-on detect pulse |
| supply_low_i | input | 1 | asynchronous supply-low comparator flag |
| wake_i | input | 1 | asynchronous wake-from-sleep event |
| osc_mode_i | input | 2 | oscillator mode code |
| pwrt_en_i | input | 1 | enables the supply settling delay |
| bor_en_i | input | 1 | enables the brown-out path |
| flag_clr_i | input | 1 | clears both cause flags |
| rc_tick_i | input | 1 | one-cycle pulse per RC clock period |
| osc_tick_i | input | 1 | one-cycle pulse per main oscillator period |
| chip_rst_o | output | 1 | internal chip reset, active high |
| por_flag_o | output | 1 | last reset came from power-on |
| bor_flag_o | output | 1 | last reset came from brown-out |

## Verification
A new supply sag and a running settling delay can meet in the same cycle. That cycle must end in brown-out hold, not in a delay tick. The bench provokes this by dropping the supply-low flag after a trip and, a few cycles into the renewed delay, raising it again for a single cycle, which is far shorter than the filter. It then compares the total number of reset cycles with the closed-form count in which the delay restarts from zero. A flag clear that lands in the same cycle as a power-on pulse is also driven, and the power-on flag must survive it.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

  typedef enum logic [2:0] {
    SEQ_PON_WAIT,
    SEQ_SAG_WAIT,
    SEQ_SETTLE,
    SEQ_XTAL,
    SEQ_ACTIVE
  } seq_state_e;

  typedef enum logic [1:0] {
    OSC_LOWPWR = 2'd0,
    OSC_STD    = 2'd1,
    OSC_FAST   = 2'd2,
    OSC_EXTCLK = 2'd3
  } osc_mode_e;

  function automatic logic mode_needs_xtal(logic [1:0] mode);
    return mode != OSC_EXTCLK;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pwr_rst_tick_cnt.sv
module pwr_rst_tick_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign done_o  = en_i && tick_i && at_last;

  // cleared whenever disabled, so every entry starts from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R5
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) ##1 en_i |-> $stable(cnt_q));

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int unsigned PWRT_TICKS = 2304,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned BOR_TICKS  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       supply_low_i,
  input  logic       wake_i,
  input  logic [1:0] osc_mode_i,
  input  logic       pwrt_en_i,
  input  logic       bor_en_i,
  input  logic       flag_clr_i,
  input  logic       rc_tick_i,
  input  logic       osc_tick_i,
  output logic       chip_rst_o,
  output logic       por_flag_o,
  output logic       bor_flag_o
);
  localparam int unsigned SYNC_W = 2;

  seq_state_e state_q, state_d;
  logic [SYNC_W-1:0] async_in, synced;
  logic low_s, wake_s, wake_prev_q, wake_rise;
  logic settle_done, xtal_done, sag_trip;
  logic xtal_req_q, xtal_req_d;
  logic por_flag_q, bor_flag_q;
  logic sag_entry, xtal_mode;

  assign async_in = {wake_i, supply_low_i};

  pwr_rst_sync #(.WIDTH(SYNC_W), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_in),
    .q_o   (synced)
  );

  assign low_s  = synced[0];
  assign wake_s = synced[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_prev_q <= 1'b0;
    else         wake_prev_q <= wake_s;
  end
  assign wake_rise = wake_s && !wake_prev_q;

  pwr_rst_tick_cnt #(.LIMIT(BOR_TICKS)) i_sag_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (bor_en_i && low_s),
    .tick_i(rc_tick_i),
    .done_o(sag_trip)
  );

  pwr_rst_tick_cnt #(.LIMIT(PWRT_TICKS)) i_settle_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == SEQ_SETTLE),
    .tick_i(rc_tick_i),
    .done_o(settle_done)
  );

  pwr_rst_tick_cnt #(.LIMIT(OST_CYCLES)) i_xtal_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == SEQ_XTAL),
    .tick_i(osc_tick_i),
    .done_o(xtal_done)
  );

  assign xtal_mode = mode_needs_xtal(osc_mode_i);
  // a sag during the settling delay bypasses the filter
  assign sag_entry = !por_i && bor_en_i &&
                     (sag_trip || (state_q == SEQ_SETTLE && low_s));

  always_comb begin
    state_d    = state_q;
    xtal_req_d = xtal_req_q;
    if (por_i) begin
      state_d    = SEQ_PON_WAIT;
      xtal_req_d = 1'b1;
    end else if (sag_entry) begin
      state_d    = SEQ_SAG_WAIT;
      xtal_req_d = 1'b0;
    end else begin
      unique case (state_q)
        SEQ_PON_WAIT: state_d = pwrt_en_i ? SEQ_SETTLE : (xtal_mode ? SEQ_XTAL : SEQ_ACTIVE);
        SEQ_SAG_WAIT: if (!low_s) state_d = pwrt_en_i ? SEQ_SETTLE : SEQ_ACTIVE;
        SEQ_SETTLE:   if (settle_done) state_d = (xtal_req_q && xtal_mode) ? SEQ_XTAL : SEQ_ACTIVE;
        SEQ_XTAL:     if (xtal_done) begin
                        state_d    = SEQ_ACTIVE;
                        xtal_req_d = 1'b0;
                      end
        SEQ_ACTIVE:   if (wake_rise && xtal_mode) state_d = SEQ_XTAL;
        default:      state_d = SEQ_PON_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_PON_WAIT;
      xtal_req_q <= 1'b1;
      por_flag_q <= 1'b1;
      bor_flag_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      xtal_req_q <= xtal_req_d;
      if (por_i) begin
        por_flag_q <= 1'b1;
        bor_flag_q <= 1'b0;
      end else if (sag_entry) begin
        por_flag_q <= 1'b0;
        bor_flag_q <= 1'b1;
      end else if (flag_clr_i) begin
        por_flag_q <= 1'b0;
        bor_flag_q <= 1'b0;
      end
    end
  end

  assign chip_rst_o = (state_q != SEQ_ACTIVE);
  assign por_flag_o = por_flag_q;
  assign bor_flag_o = bor_flag_q;

  // R12
  por_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> state_q == SEQ_PON_WAIT);

  // R8
  sag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_SAG_WAIT && low_s && !por_i) |=> state_q == SEQ_SAG_WAIT);

  // R7
  sag_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bor_en_i && !por_i && state_q != SEQ_SAG_WAIT) |=> state_q != SEQ_SAG_WAIT);

  // R11
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({por_flag_q, bor_flag_q}));

  // R10
  wake_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_ACTIVE && !por_i && !sag_entry && !flag_clr_i) |=> $stable({por_flag_q, bor_flag_q}));

endmodule

// File: tb/test_pwr_rst_seq.sv
module test_pwr_rst_seq;
  localparam int P = 5;
  localparam int O = 8;
  localparam int B = 3;

  logic clk = 1'b0, rst_n = 1'b0, por = 1'b0, vlow = 1'b0, wake = 1'b0;
  logic pwrt_en = 1'b1, bor_en = 1'b1, clr = 1'b0, rc_tick = 1'b1, osc_tick = 1'b1;
  logic [1:0] mode = 2'd1;
  logic rst_o, por_f, bor_f;
  int vec = 0, bad = 0;

  always #10 clk = ~clk;

  pwr_rst_seq #(.PWRT_TICKS(P), .OST_CYCLES(O), .BOR_TICKS(B)) i_pwr_rst_seq (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .supply_low_i(vlow), .wake_i(wake),
    .osc_mode_i(mode), .pwrt_en_i(pwrt_en), .bor_en_i(bor_en), .flag_clr_i(clr),
    .rc_tick_i(rc_tick), .osc_tick_i(osc_tick),
    .chip_rst_o(rst_o), .por_flag_o(por_f), .bor_flag_o(bor_f)
  );

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_rst(int win, output int n);
    n = 0;
    repeat (win) begin
      @(negedge clk);
      if (rst_o) n++;
    end
  endtask

  task automatic settle();
    int g = 0;
    while (rst_o && g < 500) begin
      @(negedge clk);
      g++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset chip_rst", rst_o, 1);
    chk("R1 reset por_flag", por_f, 1);
    chk("R1 reset bor_flag", bor_f, 0);
    rst_n = 1'b1;
    settle();

    // R2 R3 R4: power-on duration sweep
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        mode = 2'(m);
        pwrt_en = e[0];
        @(negedge clk); por = 1'b1;
        fork
          count_rst(40, n);
          begin @(negedge clk); por = 1'b0; end
        join
        chk($sformatf("R2 R3 R4 por duration mode=%0d en=%0d", m, e), n,
            1 + (e != 0 ? P : 0) + (m != 3 ? O : 0));
        chk("R11 por sets por_flag", por_f, 1);
        chk("R11 por clears bor_flag", bor_f, 0);
      end
    end
    pwrt_en = 1'b1;

    // R11 clear and set-wins
    pulse_clr();
    chk("R11 clear por_flag", por_f, 0);
    @(negedge clk); por = 1'b1; clr = 1'b1;
    @(negedge clk); por = 1'b0; clr = 1'b0;
    chk("R11 set beats clear", por_f, 1);
    settle();

    // R5: each stage advances only on its own tick
    mode = 2'd1;
    rc_tick = 1'b0;
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5 settle stalls without rc tick", rst_o, 1);
    rc_tick = 1'b1; osc_tick = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5 xtal count stalls without osc tick", rst_o, 1);
    @(negedge clk); osc_tick = 1'b1;
    count_rst(30, n);
    chk("R5 xtal count resumes", n, O - 1);
    settle();

    // R6 R7 R8: dip width sweep
    for (int be = 0; be < 2; be++) begin
      for (int mi = 0; mi < 2; mi++) begin
        for (int w = 1; w <= B + 2; w++) begin
          int trip;
          bor_en = be[0];
          mode = (mi != 0) ? 2'd3 : 2'd1;
          trip = (be != 0 && w >= B) ? 1 : 0;
          pulse_clr();
          @(negedge clk); vlow = 1'b1;
          fork
            count_rst(40, n);
            begin repeat (w) @(negedge clk); vlow = 1'b0; end
          join
          chk($sformatf("R6 R7 R8 dip reset cycles en=%0d mode=%0d w=%0d", be, mode, w), n,
              trip != 0 ? w - B + 1 + P : 0);
          chk("R6 R7 R11 bor_flag after dip", bor_f, trip);
          chk("R11 por_flag after dip", por_f, 0);
          settle();
        end
      end
    end

    // R9: renewed sag during settling delay
    bor_en = 1'b1; mode = 2'd1;
    @(negedge clk); vlow = 1'b1;
    fork
      count_rst(50, n);
      begin
        repeat (B + 2) @(negedge clk); vlow = 1'b0;
        repeat (3) @(negedge clk); vlow = 1'b1;
        @(negedge clk); vlow = 1'b0;
      end
    join
    chk("R9 settle restarts after resag", n, 2 + 1 + 4 + P);
    settle();

    // R10: wake sweep over modes
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      @(negedge clk); wake = 1'b1;
      count_rst(20, n);
      wake = 1'b0;
      chk($sformatf("R10 wake reset cycles mode=%0d", m), n, m != 3 ? O : 0);
      chk("R10 wake keeps bor_flag", bor_f, 1);
      chk("R10 wake keeps por_flag", por_f, 0);
      repeat (5) @(negedge clk);
    end

    // R12: por during brown-out hold
    @(negedge clk); vlow = 1'b1;
    repeat (10) @(negedge clk);
    chk("R12 in brown-out hold", rst_o, 1);
    por = 1'b1;
    @(negedge clk); por = 1'b0;
    chk("R12 por overrides por_flag", por_f, 1);
    chk("R12 por overrides bor_flag", bor_f, 0);
    vlow = 1'b0;
    settle();
    chk("R12 released after recovery", rst_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule